// File: doc/BRIEF.md
# Reloadable Three-Compare Interval Timer

This block is a single 32-bit up-counter timer driven by one of several tick-enable inputs. The chosen tick passes through a programmable prescaler, and the counter advances once for every group of prescaler ticks while the timer is running. Three compare registers are checked against the counter. Each compare has its own sticky status flag and its own interrupt enable. Software picks one of the three compares as the reload point. On the advance after the counter equals that compare, the counter restarts from a preload value instead of incrementing.

Software reaches the block through a simple word-addressed register port. Writes take one clock. Reads are combinational from the current address. The timer has a single level interrupt output. Register word offsets are: 0 control (bit 0 run, bit 1 counter-restart pulse), 1 tick source, 2 prescale value, 3 preload, 4 reload select, 5 interrupt enable, 6 status (read only), 7 flag clear (write only), 8 counter (read only), 9 to 11 compare 0 to 2.

Top module: `tmr_multimatch`

## Requirements
- R1: After a synchronous active-low reset every register, the counter, the prescaler phase and all status flags are 0, and `irq` is 0.
- R2: Control bit 0, source (2 bits), prescale (8 bits), preload, reload select (2 bits), interrupt enable (3 bits) and the compares read back the last value written, truncated to their widths. Control bit 1 and offset 7 read as 0, and unmapped offsets read 0.
- R3: With prescale value d, the counter advances once for every d+1 selected ticks while the run bit is 1. When the run bit is 0, neither the counter nor the prescaler phase changes. If d is lowered below the current phase, the next tick completes the group.
- R4: Only `tick_src[source]` counts as a tick. Ticks on the other inputs have no effect.
- R5: Status bit i is set when an advance makes the counter equal to compare i. It stays set until it is cleared.
- R6: With reload select k in 1..3, the advance taken while the counter equals compare k-1 loads the preload value. Every other advance adds 1, wrapping from all-ones to 0. Reload select 0 never reloads.
- R7: `irq` is 1 exactly when some status bit and its matching enable bit are both 1.
- R8: Writing offset 7 clears every status bit whose data bit is 1. A hit in the same cycle keeps its bit set.
- R9: Writing 1 to control bit 1 loads 0 into the counter and into the prescaler phase in that cycle, taking priority over an advance, and raises no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_src | input | NSRC | Candidate tick-enable inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A wrong prescaler phase or a wrong source choice shows up as a counter read that runs ahead of or behind the model. This becomes visible within one tick group. A bad compare or reload decision shows up one advance later, either as a counter that keeps incrementing past the reload compare or as a status flag that is missing or extra. That in turn flips `irq` in the same cycle, provided the flag is enabled. Lost clears and lost sticky state appear at the next status read, and the bench reads random offsets on nearly every cycle.

// File: rtl/tmr_pkg.sv
// Package: shared register offsets and sizes for the reloadable compare timer.
// Assumes a word-addressed register port with 4-bit offsets.
package tmr_pkg;
    localparam int ADDR_W    = 4;
    localparam int NUM_MATCH = 3;
    localparam int PRE_W     = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_SRC    = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_DIV    = 4'd2;
    localparam logic [ADDR_W-1:0] OFF_PRE    = 4'd3;
    localparam logic [ADDR_W-1:0] OFF_RSEL   = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 4'd7;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_MATCH0 = 4'd9;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_RESTART_BIT = 1;
endpackage

// File: rtl/tmr_regs.sv
// Module: software-visible configuration registers of the timer.
// Assumes single-cycle writes; read muxing is done by the parent.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NSRC    = 4,
    localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int RSEL_W = $clog2(NUM_MATCH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    output logic                            run,
    output logic [SRC_W-1:0]                src,
    output logic [PRE_W-1:0]                div,
    output logic [CNT_W-1:0]                preload,
    output logic [RSEL_W-1:0]               rsel,
    output logic [NUM_MATCH-1:0]            ien,
    output logic [NUM_MATCH-1:0][CNT_W-1:0] match
);
    // Scalar configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            src     <= '0;
            div     <= '0;
            preload <= '0;
            rsel    <= '0;
            ien     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFF_CTRL: run     <= wr_data[CTRL_RUN_BIT];
                OFF_SRC:  src     <= wr_data[SRC_W-1:0];
                OFF_DIV:  div     <= wr_data[PRE_W-1:0];
                OFF_PRE:  preload <= wr_data;
                OFF_RSEL: rsel    <= wr_data[RSEL_W-1:0];
                OFF_IEN:  ien     <= wr_data[NUM_MATCH-1:0];
                default: ;
            endcase
        end
    end

    // One compare register per match slot at consecutive offsets.
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
        localparam logic [ADDR_W-1:0] MY_OFF = OFF_MATCH0 + ADDR_W'(g);
        // Capture compare value g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                match[g] <= '0;
            else if (wr_en && wr_addr == MY_OFF)
                match[g] <= wr_data;
        end
    end
endmodule

// File: rtl/tmr_prescale.sv
// Module: tick source selection and divide-by-(d+1) prescaler.
// Assumes tick inputs are synchronous single-cycle enables.
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int NSRC   = 4,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [NSRC-1:0]  tick_src,
    input  logic [SRC_W-1:0] src,
    input  logic [PRE_W-1:0] div,
    output logic             adv
);
    logic [PRE_W-1:0] phase;
    logic             tick;
    logic             last;

    // Pick the selected tick input; out-of-range selects give no tick.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (src == SRC_W'(i)) tick = tick_src[i];
    end

    assign last = (phase >= div);
    assign adv  = run && tick && last;

    // Advance the phase on each counted tick; restart forces it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (run && tick)
            phase <= last ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
// Module: up-counter with reload-on-selected-compare and per-compare hits.
// Assumes rsel = 0 disables reload, rsel = k selects compare k-1.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    localparam int RSEL_W = $clog2(NUM_MATCH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            adv,
    input  logic                            restart,
    input  logic [RSEL_W-1:0]               rsel,
    input  logic [CNT_W-1:0]                preload,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match,
    output logic [CNT_W-1:0]                count,
    output logic [NUM_MATCH-1:0]            hit
);
    logic [NUM_MATCH-1:0] eq_now;
    logic [NUM_MATCH-1:0] sel_hot;
    logic                 reload;
    logic [CNT_W-1:0]     next_val;

    // Per-compare equality with the current count and one-hot reload select.
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        assign eq_now[g]  = (count == match[g]);
        assign sel_hot[g] = (rsel == RSEL_W'(g + 1));
        assign hit[g]     = adv && !restart && (next_val == match[g]);
    end

    assign reload   = |(eq_now & sel_hot);
    assign next_val = reload ? preload : count + 1'b1;

    // Counter register: restart wins, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            count <= '0;
        else if (adv)
            count <= next_val;
    end
endmodule

// File: rtl/tmr_status.sv
// Module: sticky compare flags with write-1-to-clear and masked interrupt.
// Assumes hit and clear may coincide; the hit is kept.
module tmr_status
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MATCH-1:0] hit,
    input  logic [NUM_MATCH-1:0] clr_mask,
    input  logic [NUM_MATCH-1:0] ien,
    output logic [NUM_MATCH-1:0] status,
    output logic                 irq
);
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_flag
        // Flag g: set on hit, cleared by a 1 in the clear mask.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[g] <= 1'b0;
            else if (hit[g])
                status[g] <= 1'b1;
            else if (clr_mask[g])
                status[g] <= 1'b0;
        end
    end

    assign irq = |(status & ien);
endmodule

// File: rtl/tmr_multimatch.sv
// Module: top of the reloadable three-compare timer; wires the register
// file, prescaler, counter and status, and muxes read data.
// Assumes CNT_W >= PRE_W and a word-addressed register port.
module tmr_multimatch
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NSRC    = 4,
    localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int RSEL_W = $clog2(NUM_MATCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   tick_src,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    logic                            run;
    logic [SRC_W-1:0]                src;
    logic [PRE_W-1:0]                div;
    logic [CNT_W-1:0]                preload;
    logic [RSEL_W-1:0]               rsel;
    logic [NUM_MATCH-1:0]            ien;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match;
    logic                            restart;
    logic                            adv;
    logic [CNT_W-1:0]                count;
    logic [NUM_MATCH-1:0]            hit;
    logic [NUM_MATCH-1:0]            status;
    logic [NUM_MATCH-1:0]            clr_mask;

    assign restart  = bus_we && (bus_addr == OFF_CTRL) && bus_wdata[CTRL_RESTART_BIT];
    assign clr_mask = (bus_we && bus_addr == OFF_ICLR) ? bus_wdata[NUM_MATCH-1:0] : '0;

    tmr_regs #(.CNT_W(CNT_W), .NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .run(run), .src(src), .div(div),
        .preload(preload), .rsel(rsel), .ien(ien), .match(match)
    );

    tmr_prescale #(.NSRC(NSRC)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .tick_src(tick_src), .src(src), .div(div), .adv(adv)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv), .restart(restart),
        .rsel(rsel), .preload(preload), .match(match),
        .count(count), .hit(hit)
    );

    tmr_status u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr_mask(clr_mask),
        .ien(ien), .status(status), .irq(irq)
    );

    // Read mux over the register map; write-only and unmapped offsets read 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL:  bus_rdata = CNT_W'(run);
            OFF_SRC:   bus_rdata = CNT_W'(src);
            OFF_DIV:   bus_rdata = CNT_W'(div);
            OFF_PRE:   bus_rdata = preload;
            OFF_RSEL:  bus_rdata = CNT_W'(rsel);
            OFF_IEN:   bus_rdata = CNT_W'(ien);
            OFF_STAT:  bus_rdata = CNT_W'(status);
            OFF_COUNT: bus_rdata = count;
            default: begin
                for (int i = 0; i < NUM_MATCH; i++)
                    if (bus_addr == OFF_MATCH0 + ADDR_W'(i)) bus_rdata = match[i];
            end
        endcase
    end
endmodule

// File: rtl/tmr_multimatch_chk.sv
// Checker: temporal properties of the timer, bound into the top module.
module tmr_multimatch_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic                 run,
    input logic                 adv,
    input logic                 restart,
    input logic [CNT_W-1:0]     count,
    input logic [CNT_W-1:0]     preload,
    input logic [NUM_MATCH-1:0] status,
    input logic [NUM_MATCH-1:0] clr_mask
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && status == '0 && !irq));

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(count));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart) |=> (count == CNT_W'($past(count) + 1'b1)) || (count == $past(preload)));

    p_no_flag_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status & $past(status)) == $past(status)));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
endmodule

bind tmr_multimatch tmr_multimatch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .run(run), .adv(adv),
    .restart(restart), .count(count), .preload(preload),
    .status(status), .clr_mask(clr_mask)
);

// File: tb/tb_tmr_multimatch.sv
module tb_tmr_multimatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic        m_run;
    logic [1:0]  m_src, m_rsel;
    logic [7:0]  m_div, m_ph;
    logic [31:0] m_pre, m_cnt;
    logic [2:0]  m_ien, m_st;
    logic [31:0] m_match [3];

    always #2.5 clk = ~clk;

    tmr_multimatch dut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {31'b0, m_run};
            4'd1: return {30'b0, m_src};
            4'd2: return {24'b0, m_div};
            4'd3: return m_pre;
            4'd4: return {30'b0, m_rsel};
            4'd5: return {29'b0, m_ien};
            4'd6: return {29'b0, m_st};
            4'd8: return m_cnt;
            4'd9, 4'd10, 4'd11: return m_match[a - 4'd9];
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        m_run = 0; m_src = 0; m_rsel = 0; m_div = 0; m_ph = 0;
        m_pre = 0; m_cnt = 0; m_ien = 0; m_st = 0;
        for (int i = 0; i < 3; i++) m_match[i] = 0;
    endtask

    // One clock edge of the reference from the currently driven inputs.
    task automatic m_step();
        logic rst_c, tick, adv, rl;
        logic [31:0] nx;
        logic [2:0] hit, clr;
        rst_c = bus_we && bus_addr == 4'd0 && bus_wdata[1];
        tick  = tick_src[m_src];
        adv   = m_run && tick && (m_ph >= m_div);
        rl    = (m_rsel != 0) && (m_cnt == m_match[m_rsel - 2'd1]);
        nx    = rl ? m_pre : m_cnt + 1;
        for (int i = 0; i < 3; i++) hit[i] = adv && !rst_c && (nx == m_match[i]);
        clr   = (bus_we && bus_addr == 4'd7) ? bus_wdata[2:0] : 3'b0;
        if (rst_c) m_ph = 0;
        else if (m_run && tick) m_ph = (m_ph >= m_div) ? 8'd0 : m_ph + 8'd1;
        if (rst_c) m_cnt = 0;
        else if (adv) m_cnt = nx;
        m_st = (m_st & ~clr) | hit;
        if (bus_we) begin
            case (bus_addr)
                4'd0: m_run = bus_wdata[0];
                4'd1: m_src = bus_wdata[1:0];
                4'd2: m_div = bus_wdata[7:0];
                4'd3: m_pre = bus_wdata;
                4'd4: m_rsel = bus_wdata[1:0];
                4'd5: m_ien = bus_wdata[2:0];
                4'd9, 4'd10, 4'd11: m_match[bus_addr - 4'd9] = bus_wdata;
                default: ;
            endcase
        end
    endtask

    // Inputs already driven at the falling edge; check read data, clock, check irq.
    task automatic cyc();
        string tag;
        #1;
        tag = (bus_addr == 4'd8) ? "R6 count" : (bus_addr == 4'd6) ? "R5 status" : "R2 read";
        check(tag, bus_rdata, m_read(bus_addr));
        @(posedge clk);
        m_step();
        @(negedge clk);
        check("R7 irq", {31'b0, irq}, {31'b0, |(m_st & m_ien)});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd_chk("R1 count", 4'd8, 32'h0);
        rd_chk("R1 status", 4'd6, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3: divide by 3 on source 1
        wr(4'd1, 32'd1); wr(4'd2, 32'd2); wr(4'd0, 32'h3);
        tick_src = 4'b0010;
        repeat (9) cyc();
        tick_src = 4'b0000;
        rd_chk("R3 divide", 4'd8, 32'd3);
        // R4: other sources ignored
        tick_src = 4'b1101;
        repeat (5) cyc();
        tick_src = 4'b0000;
        rd_chk("R4 src ignore", 4'd8, 32'd3);
        // R3: stopped counter holds
        wr(4'd0, 32'h0);
        tick_src = 4'b0010;
        repeat (6) cyc();
        rd_chk("R3 stopped", 4'd8, 32'd3);

        // R6/R5: reload from compare 1
        wr(4'd2, 32'd0); wr(4'd10, 32'd4); wr(4'd3, 32'd1); wr(4'd4, 32'd2);
        tick_src = 4'b0000;
        wr(4'd0, 32'h3);
        tick_src = 4'b0010;
        repeat (5) cyc();
        tick_src = 4'b0000;
        rd_chk("R6 reload", 4'd8, 32'd1);
        rd_chk("R5 flag", 4'd6, 32'd2);
        // R7
        wr(4'd5, 32'd1);
        check("R7 masked", {31'b0, irq}, 32'h0);
        wr(4'd5, 32'd2);
        check("R7 enabled", {31'b0, irq}, 32'h1);
        // R8
        wr(4'd7, 32'd2);
        rd_chk("R8 clear", 4'd6, 32'd0);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        // R8: hit and clear in the same cycle keeps the flag (count 1 -> 2 == compare 0)
        wr(4'd9, 32'd2);
        tick_src = 4'b0010;
        wr(4'd7, 32'd1);
        tick_src = 4'b0000;
        rd_chk("R8 hit wins", 4'd6, 32'd1);
        // R9: restart with a tick present
        tick_src = 4'b0010;
        wr(4'd0, 32'h3);
        tick_src = 4'b0000;
        rd_chk("R9 restart", 4'd8, 32'd0);
        // R2: write-only offsets read zero
        rd_chk("R2 iclr reads 0", 4'd7, 32'd0);
        rd_chk("R2 unmapped", 4'd14, 32'd0);

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            logic [3:0] a;
            logic [31:0] d;
            tick_src = 4'($urandom);
            if ($urandom % 6 == 0) begin
                a = 4'($urandom % 12);
                d = $urandom;
                if (a == 4'd3 || a >= 4'd9) d = d & 32'h1F;
                if (a == 4'd2) d = d & 32'h3;
                if (a == 4'd0) d = {30'b0, ($urandom % 8 == 0), ($urandom % 5 != 0)};
                wr(a, d);
            end else begin
                bus_addr = 4'($urandom % 12);
                cyc();
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule